// File: doc/BRIEF.md
# Asynchronous Static Memory Interface Controller

This block lets a synchronous on-chip requester read and write an external asynchronous static device such as SRAM, ROM or NOR-style flash. A request arrives with a byte address, a write flag, an access size and write data under a valid/ready handshake. The controller then sequences chip select, output enable and write enable on its own clock. The external bidirectional data bus is modelled as an output bus, an input bus and a drive-enable.

Every access follows the same pattern. Chip select falls first. After a programmable lead time the read or write strobe falls and stays low for a programmable number of wait cycles. Reads capture the data while the output strobe is still low and return it with a one-cycle response pulse. Writes keep the address and data steady until one cycle after the write strobe has risen. A programmable idle gap then separates the access from the next one. The timing settings are sampled when a request is accepted. Accesses of 8, 16 or 32 bits choose byte lanes from the low address bits.

Top module: `static_mem_ctrl`

## Requirements
- R1: While reset is held and after it is released, chip select, output strobe and write strobe are high (inactive), the data drive-enable is low, the request ready is high and the response valid is low.
- R2: For an accepted request, chip select falls in the first cycle after the accepting edge and stays low for 1+L cycles before the strobe falls. L is the output-strobe lead setting for reads and the write-strobe lead setting for writes.
- R3: The strobe (output strobe for reads, write strobe for writes) stays low for exactly 1+W cycles, where W is the wait setting. The two strobes are never low together, and neither is ever low while chip select is high.
- R4: A read raises the response valid for exactly one cycle: the cycle right after the last strobe cycle. The data returned is the data sampled in that last strobe cycle.
- R5: During a write, the word address, byte enables and output data stay constant from the first chip-select cycle on. The drive-enable is high from the first chip-select cycle through the single cycle after the write strobe rises. Chip select stays low for that cycle and rises at its end.
- R6: After chip select rises, it stays high with ready low for exactly T cycles (T is the turnaround setting). With T = 0, ready is high in the cycle right after chip select rises.
- R7: Ready is low from the accepting edge until the turnaround ends. A valid request presented while ready is low is not taken and does not disturb the access in progress.
- R8: Size code 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. The active-low byte enables select the naturally aligned group of lanes that contains byte offset addr[1:0]; lane i covers data bits 8i+7..8i. The memory word address is addr[ADDR_W-1:2]. Write data is taken from the low bits of the request data and repeated across every lane group.
- R9: Read data is taken from the selected lanes, shifted down to bit 0 and zero-extended.
- R10: The lead, wait and turnaround settings are sampled at acceptance. Changing them during an access has no effect on that access.
- R11: The data drive-enable is never high during a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| req_wdata | input | DATA_W | Write data, low-aligned |
| cfg_oe_dly | input | CNT_W | Extra cycles from chip select to output strobe |
| cfg_we_dly | input | CNT_W | Extra cycles from chip select to write strobe |
| cfg_wait | input | CNT_W | Extra strobe cycles |
| cfg_turn | input | CNT_W | Idle cycles after chip select rises |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Aligned read data |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_be_n | output | DATA_W/8 | Active-low byte enables |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive-enable |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The assertions check the following on every cycle: strobes are exclusive and appear only under chip select, the address and driven data hold steady while selected, the bus is driven whenever the write strobe is low, the bus is never driven under the output strobe, ready appears only with chip select high, and the response is a single-cycle pulse. Exact lead, wait and turnaround counts, lane selection, read alignment, write effects on the memory, and the sampling of settings at acceptance can only be shown by the bench's scenarios. There, a cycle-exact model built from the settings predicts every output on every clock.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_STRB  = 3'd2,
        ST_RECOV = 3'd3,
        ST_TURN  = 3'd4
    } smc_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/smc_lane_map.sv
module smc_lane_map #(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] off,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be_n,
    output logic [DATA_W-1:0] wrep
);
    int sh_w;
    int nb_w;
    int base_w;

    always_comb begin
        sh_w   = (int'(size) >= LANE_W) ? LANE_W : int'(size);
        nb_w   = 1 << sh_w;
        base_w = (int'(off) >> sh_w) << sh_w;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_n[g] = !((g >= base_w) && (g < base_w + nb_w));
        assign wrep[g*8 +: 8] = wdata[(g % nb_w)*8 +: 8];
    end

endmodule

// File: rtl/smc_rd_align.sv
module smc_rd_align #(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] off,
    output logic [DATA_W-1:0] aligned
);
    int sh_r;
    int nb_r;
    int base_r;

    always_comb begin
        sh_r   = (int'(size) >= LANE_W) ? LANE_W : int'(size);
        nb_r   = 1 << sh_r;
        base_r = (int'(off) >> sh_r) << sh_r;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_byte
        assign aligned[j*8 +: 8] = (j < nb_r) ? raw[((base_r + j) % LANES)*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/smc_seq.sv
module smc_seq #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int WA_W   = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [WA_W-1:0]   req_waddr,
    input  logic [LANES-1:0]  req_be_n,
    input  logic [DATA_W-1:0] req_wrep,
    input  logic [1:0]        req_size,
    input  logic [LANE_W-1:0] req_off,
    input  logic [CNT_W-1:0]  cfg_oe_dly,
    input  logic [CNT_W-1:0]  cfg_we_dly,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_turn,
    input  logic [DATA_W-1:0] rd_aligned,
    output logic [1:0]        cur_size,
    output logic [LANE_W-1:0] cur_off,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [WA_W-1:0]   mem_addr,
    output logic [LANES-1:0]  mem_be_n,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    import smc_pkg::*;

    typedef struct packed {
        smc_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [CNT_W-1:0]  wait_n;
        logic [CNT_W-1:0]  turn_n;
        logic              cs_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              rsp_valid;
        logic [WA_W-1:0]   addr;
        logic [LANES-1:0]  be_n;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        size;
        logic [LANE_W-1:0] off;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_LEAD;
                    d.wr     = req_write;
                    d.cnt    = req_write ? cfg_we_dly : cfg_oe_dly;
                    d.wait_n = cfg_wait;
                    d.turn_n = cfg_turn;
                    d.addr   = req_waddr;
                    d.be_n   = req_be_n;
                    d.wdata  = req_wrep;
                    d.size   = req_size;
                    d.off    = req_off;
                    d.cs_n   = 1'b0;
                    d.dq_oe  = req_write;
                end
            end
            ST_LEAD: begin
                if (q.cnt == '0) begin
                    d.st   = ST_STRB;
                    d.cnt  = q.wait_n;
                    d.oe_n = q.wr;
                    d.we_n = !q.wr;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_STRB: begin
                if (q.cnt == '0) begin
                    d.oe_n = 1'b1;
                    d.we_n = 1'b1;
                    if (q.wr) begin
                        d.st = ST_RECOV;
                    end else begin
                        d.rdata     = rd_aligned;
                        d.rsp_valid = 1'b1;
                        d.cs_n      = 1'b1;
                        d.st        = (q.turn_n == '0) ? ST_IDLE : ST_TURN;
                        d.cnt       = q.turn_n - 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RECOV: begin
                d.cs_n  = 1'b1;
                d.dq_oe = 1'b0;
                d.st    = (q.turn_n == '0) ? ST_IDLE : ST_TURN;
                d.cnt   = q.turn_n - 1'b1;
            end
            ST_TURN: begin
                if (q.cnt == '0) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
            q.oe_n <= 1'b1;
            q.we_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign cur_size   = q.size;
    assign cur_off    = q.off;
    assign rsp_valid  = q.rsp_valid;
    assign rsp_rdata  = q.rdata;
    assign mem_addr   = q.addr;
    assign mem_be_n   = q.be_n;
    assign mem_cs_n   = q.cs_n;
    assign mem_oe_n   = q.oe_n;
    assign mem_we_n   = q.we_n;
    assign mem_dq_out = q.wdata;
    assign mem_dq_oe  = q.dq_oe;

    AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R3
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n))); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R5
    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe); // R5
    AST_WE_RELEASE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_cs_n); // R5
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R11
    AST_READY_ONLY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n); // R7
    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4

endmodule

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int WA_W   = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_oe_dly,
    input  logic [CNT_W-1:0]  cfg_we_dly,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_turn,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [WA_W-1:0]   mem_addr,
    output logic [LANES-1:0]  mem_be_n,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic [LANES-1:0]  req_be_n;
    logic [DATA_W-1:0] req_wrep;
    logic [DATA_W-1:0] rd_aligned;
    logic [1:0]        cur_size;
    logic [LANE_W-1:0] cur_off;

    smc_lane_map #(.DATA_W(DATA_W)) u_lane_map (
        .off   (req_addr[LANE_W-1:0]),
        .size  (req_size),
        .wdata (req_wdata),
        .be_n  (req_be_n),
        .wrep  (req_wrep)
    );

    smc_rd_align #(.DATA_W(DATA_W)) u_rd_align (
        .raw     (mem_dq_in),
        .size    (cur_size),
        .off     (cur_off),
        .aligned (rd_aligned)
    );

    smc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_waddr  (req_addr[ADDR_W-1:LANE_W]),
        .req_be_n   (req_be_n),
        .req_wrep   (req_wrep),
        .req_size   (req_size),
        .req_off    (req_addr[LANE_W-1:0]),
        .cfg_oe_dly (cfg_oe_dly),
        .cfg_we_dly (cfg_we_dly),
        .cfg_wait   (cfg_wait),
        .cfg_turn   (cfg_turn),
        .rd_aligned (rd_aligned),
        .cur_size   (cur_size),
        .cur_off    (cur_off),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_be_n   (mem_be_n),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

endmodule

// File: tb/static_mem_ctrl_bench.sv
module static_mem_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic [3:0]  cfg_oe_dly = '0, cfg_we_dly = '0, cfg_wait = '0, cfg_turn = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic [3:0]  mem_be_n;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [31:0] mem_dq_out;
    logic [31:0] mem_dq_in;

    always #5 clk = ~clk;

    static_mem_ctrl u_static_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .cfg_oe_dly(cfg_oe_dly), .cfg_we_dly(cfg_we_dly),
        .cfg_wait(cfg_wait), .cfg_turn(cfg_turn), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // external device model: drives only while selected and output strobe low
    logic [31:0] dev [16];
    logic [31:0] shadow [16];
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? dev[mem_addr[3:0]] : 32'hA5A5_A5A5;

    always @(posedge mem_we_n) begin
        if (mem_cs_n === 1'b0 && mem_dq_oe === 1'b1) begin
            for (int i = 0; i < 4; i++)
                if (!mem_be_n[i]) dev[mem_addr[3:0]][8*i +: 8] <= mem_dq_out[8*i +: 8];
        end
    end

    typedef struct packed {
        logic        cs_n, oe_n, we_n, dq_oe, ready, rsp;
        logic [31:0] rdata;
        logic [17:0] addr;
        logic [3:0]  be_n;
        logic [31:0] dout;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    exp_t idle_e;
    int   checks = 0;
    int   failures = 0;
    bit   accepted;
    bit   in_read;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model: on acceptance, build the whole per-cycle expectation from the requirements
    task automatic push_seq();
        int    nb, off, base, widx, lead;
        exp_t  e;
        logic [3:0]  be;
        logic [31:0] dout, rdata;
        nb   = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;
        off  = int'(req_addr[1:0]);
        base = (off / nb) * nb;
        widx = int'(req_addr[5:2]);
        rdata = '0;
        for (int i = 0; i < 4; i++) begin
            be[i] = !(i >= base && i < base + nb);
            dout[8*i +: 8] = req_wdata[8*(i % nb) +: 8];
        end
        if (req_write) begin
            for (int i = 0; i < 4; i++) if (!be[i]) shadow[widx][8*i +: 8] = dout[8*i +: 8];
        end else begin
            for (int j = 0; j < nb; j++) rdata[8*j +: 8] = shadow[widx][8*(base + j) +: 8];
        end
        lead = req_write ? int'(cfg_we_dly) : int'(cfg_oe_dly);
        e = '0;
        e.addr = req_addr[19:2];
        e.be_n = be;
        e.dout = dout;
        e.cs_n = 1'b0; e.oe_n = 1'b1; e.we_n = 1'b1; e.dq_oe = req_write; e.ready = 1'b0;
        for (int i = 0; i <= lead; i++) q.push_back(e);
        e.oe_n = req_write; e.we_n = !req_write;
        for (int i = 0; i <= int'(cfg_wait); i++) q.push_back(e);
        e.oe_n = 1'b1; e.we_n = 1'b1;
        if (req_write) q.push_back(e);
        e.cs_n = 1'b1; e.dq_oe = 1'b0;
        for (int i = 0; i < int'(cfg_turn); i++) begin
            e.rsp = (!req_write && i == 0);
            e.rdata = rdata;
            q.push_back(e);
        end
        if (!req_write && cfg_turn == 4'd0) begin
            e = idle_e;
            e.rsp = 1'b1;
            e.rdata = rdata;
            q.push_back(e);
        end
        in_read = !req_write;
    endtask

    task automatic compare();
        chk(mem_cs_n === cur.cs_n, "R2/R6 cs_n", {31'd0, mem_cs_n}, {31'd0, cur.cs_n});
        chk(mem_oe_n === cur.oe_n, "R3 oe_n", {31'd0, mem_oe_n}, {31'd0, cur.oe_n});
        chk(mem_we_n === cur.we_n, "R3 we_n", {31'd0, mem_we_n}, {31'd0, cur.we_n});
        chk(mem_dq_oe === cur.dq_oe, in_read ? "R11 dq_oe" : "R5 dq_oe",
            {31'd0, mem_dq_oe}, {31'd0, cur.dq_oe});
        chk(req_ready === cur.ready, "R7 ready", {31'd0, req_ready}, {31'd0, cur.ready});
        chk(rsp_valid === cur.rsp, "R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, cur.rsp});
        if (cur.rsp) chk(rsp_rdata === cur.rdata, "R9 rdata", rsp_rdata, cur.rdata);
        if (!cur.cs_n) begin
            chk(mem_addr === cur.addr, "R5 addr", {14'd0, mem_addr}, {14'd0, cur.addr});
            chk(mem_be_n === cur.be_n, "R8 be_n", {28'd0, mem_be_n}, {28'd0, cur.be_n});
        end
        if (cur.dq_oe) chk(mem_dq_out === cur.dout, "R8 dq_out", mem_dq_out, cur.dout);
    endtask

    task automatic tick();
        if (req_valid && cur.ready) begin
            push_seq();
            accepted = 1'b1;
        end
        @(negedge clk);
        if (q.size() > 0) cur = q.pop_front();
        else cur = idle_e;
        compare();
    endtask

    task automatic issue(input bit wr, input logic [19:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [3:0] od, input logic [3:0] wdl,
                         input logic [3:0] wt, input logic [3:0] tt);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        cfg_oe_dly = od; cfg_we_dly = wdl; cfg_wait = wt; cfg_turn = tt;
        accepted = 1'b0;
        while (!accepted) tick();
        req_valid = 1'b0;
    endtask

    task automatic settle();
        while (q.size() > 0) tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_e = '0;
        idle_e.cs_n = 1'b1; idle_e.oe_n = 1'b1; idle_e.we_n = 1'b1; idle_e.ready = 1'b1;
        cur = idle_e;
        in_read = 1'b0;
        for (int k = 0; k < 16; k++) begin
            dev[k] = 32'h1020_3040 + k * 32'h0101_0101;
            shadow[k] = 32'h1020_3040 + k * 32'h0101_0101;
        end
        repeat (3) @(negedge clk);
        compare();                // R1 during reset
        rst_n = 1'b1;
        tick();                   // R1 after release
        // R2 R3 R4: plain word read, zero lead/wait/turn
        issue(1'b0, 20'h00004, 2'd2, 32'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        settle();
        // R9: byte read at offset 3 with lead, wait and turnaround
        issue(1'b0, 20'h0000B, 2'd0, 32'h0, 4'd2, 4'd0, 4'd3, 4'd2);
        settle();
        // R5 R6: word write then read back
        issue(1'b1, 20'h00010, 2'd2, 32'hCAFE_F00D, 4'd0, 4'd1, 4'd2, 4'd1);
        issue(1'b0, 20'h00010, 2'd2, 32'h0, 4'd1, 4'd0, 4'd1, 4'd0);
        settle();
        // R8: byte write at offset 2, half write at offset 1, read whole word
        issue(1'b1, 20'h00016, 2'd0, 32'h0000_00EE, 4'd0, 4'd0, 4'd0, 4'd0);
        issue(1'b1, 20'h00019, 2'd1, 32'h0000_BEEF, 4'd0, 4'd2, 4'd0, 4'd2);
        issue(1'b0, 20'h00014, 2'd2, 32'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        issue(1'b0, 20'h00018, 2'd3, 32'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        settle();
        // R9: half read at offset 3 selects upper half
        issue(1'b0, 20'h00007, 2'd1, 32'h0, 4'd0, 4'd0, 4'd1, 4'd1);
        settle();
        // R10: settings changed during the access are not used
        issue(1'b1, 20'h00020, 2'd2, 32'h1357_9BDF, 4'd1, 4'd3, 4'd2, 4'd2);
        cfg_oe_dly = 4'd9; cfg_we_dly = 4'd0; cfg_wait = 4'd7; cfg_turn = 4'd0;
        settle();
        // R7: a different request held valid while busy is not taken
        issue(1'b0, 20'h00020, 2'd2, 32'h0, 4'd2, 4'd2, 4'd2, 4'd3);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00030; req_wdata = 32'hDEAD_0000;
        tick(); tick(); tick();
        req_valid = 1'b0;
        settle();
        // R6: back-to-back with zero turnaround, then maximum settings
        issue(1'b1, 20'h00024, 2'd2, 32'h0F0F_0F0F, 4'd0, 4'd0, 4'd0, 4'd0);
        issue(1'b0, 20'h00024, 2'd2, 32'h0, 4'd0, 4'd0, 4'd0, 4'd0);
        issue(1'b0, 20'h00021, 2'd0, 32'h0, 4'd15, 4'd15, 4'd15, 4'd15);
        issue(1'b1, 20'h0002C, 2'd2, 32'h8765_4321, 4'd15, 4'd15, 4'd15, 4'd15);
        issue(1'b0, 20'h0002C, 2'd2, 32'h0, 4'd0, 4'd0, 4'd0, 4'd1);
        settle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule